// File: doc/BRIEF.md
# Paired Traffic Signal Sequencer

This block drives two opposing traffic signals, each with a red, an amber and a green lamp. It has no timer of its own. One external timing level, sampled on each rising clock edge, chooses the phase. While the timing level is low, one signal shows green and the other shows red. When the level goes high, the green signal changes to amber and the red signal stays red. When the level falls again, the amber signal changes to red and the signal that was red changes to green. The phases run in a fixed cycle of four.

The phase is held in a two-bit register. An asynchronous active-low reset clears it. All six lamp outputs are decoded from that register alone, so they change only at a clock edge. The current phase code is also an output, so that a surrounding controller can read it.

Top module: `traffic_pair_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, the phase code is 0: signal 1 shows green and signal 2 shows red. Reset acts without waiting for a clock edge.
- R2: In a green phase (code 0 or 2), a rising clock edge that samples the timing input low leaves the phase unchanged.
- R3: In a green phase, a rising edge that samples the timing input high moves to the amber phase of the same signal (0 to 1, 2 to 3). The other signal stays red.
- R4: In an amber phase (code 1 or 3), a rising edge that samples the timing input high leaves the phase unchanged.
- R5: In an amber phase, a rising edge that samples the timing input low moves to the green phase of the other signal (1 to 2, 3 to 0). The amber signal becomes red.
- R6: In every cycle, each signal has exactly one lamp lit.
- R7: The two signals are never both showing something other than red.
- R8: The phase codes map to lamps as follows. Code 0: signal 1 green, signal 2 red. Code 1: signal 1 amber, signal 2 red. Code 2: signal 1 red, signal 2 green. Code 3: signal 1 red, signal 2 amber.
- R9: The lamps and the phase code change only at rising clock edges. A change of the timing input between edges has no effect on the outputs until the next edge samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timing input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| timing_i | input | 1 | External timing level: high requests amber, low requests green |
| sig1_red | output | 1 | Signal 1 red lamp |
| sig1_amber | output | 1 | Signal 1 amber lamp |
| sig1_green | output | 1 | Signal 1 green lamp |
| sig2_red | output | 1 | Signal 2 red lamp |
| sig2_amber | output | 1 | Signal 2 amber lamp |
| sig2_green | output | 1 | Signal 2 green lamp |
| phase_o | output | 2 | Current phase code (see R8) |

## Verification
The timing input is driven as alternating low and high intervals. The length of each interval sweeps from one to five cycles, and every combination of lengths is used. One-cycle intervals show whether a phase can be skipped or entered a cycle late. Longer intervals show whether a phase holds while the level is steady. Each sweep runs through two complete rounds, so both the signal 1 and the signal 2 halves of the cycle are covered. A glitch on the timing input between clock edges, and a reset asserted in the middle of the cycle, are used to check the clock-only and asynchronous behaviour.

// File: rtl/traffic_pair_pkg.sv
package traffic_pair_pkg;

  localparam int unsigned PHASE_W = 2;
  localparam int unsigned SIG_N   = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_GO1   = 2'd0,
    PH_WARN1 = 2'd1,
    PH_GO2   = 2'd2,
    PH_WARN2 = 2'd3
  } phase_t;

  typedef struct packed {
    logic red;
    logic amber;
    logic green;
  } lamp_t;

  // next phase from current phase and sampled timing level
  function automatic phase_t phase_next(phase_t p, logic t);
    phase_t n;
    case (p)
      PH_GO1:   n = t ? PH_WARN1 : PH_GO1;
      PH_WARN1: n = t ? PH_WARN1 : PH_GO2;
      PH_GO2:   n = t ? PH_WARN2 : PH_GO2;
      PH_WARN2: n = t ? PH_WARN2 : PH_GO1;
      default:  n = PH_GO1;
    endcase
    return n;
  endfunction

  // lamp pattern of signal idx in phase p: signal idx owns codes 2*idx and 2*idx+1
  function automatic lamp_t lamp_of(phase_t p, int unsigned idx);
    lamp_t l;
    l = '{red: 1'b1, amber: 1'b0, green: 1'b0};
    if (int'(p) == int'(2*idx))
      l = '{red: 1'b0, amber: 1'b0, green: 1'b1};
    else if (int'(p) == int'(2*idx + 1))
      l = '{red: 1'b0, amber: 1'b1, green: 1'b0};
    return l;
  endfunction

endpackage

// File: rtl/traffic_phase_seq.sv
module traffic_phase_seq
  import traffic_pair_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   timing_i,
  output phase_t phase_o,
  output logic   advance_o
);

  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    phase_d   = phase_next(phase_q, timing_i);
    advance_o = (phase_d != phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_GO1;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R2
  green_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!timing_i && !phase_q[0]) |=> $stable(phase_q));

  // R3
  go1_to_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_i && phase_q == PH_GO1) |=> (phase_q == PH_WARN1));

  // R3
  go2_to_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_i && phase_q == PH_GO2) |=> (phase_q == PH_WARN2));

  // R4
  amber_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_i && phase_q[0]) |=> $stable(phase_q));

  // R5
  warn1_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!timing_i && phase_q == PH_WARN1) |=> (phase_q == PH_GO2));

  // R5
  warn2_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!timing_i && phase_q == PH_WARN2) |=> (phase_q == PH_GO1));

endmodule

// File: rtl/traffic_lamp_decode.sv
module traffic_lamp_decode
  import traffic_pair_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  phase_t              phase_i,
  output lamp_t [SIG_N-1:0]   lamps_o
);

  for (genvar g = 0; g < SIG_N; g++) begin : g_sig
    assign lamps_o[g] = lamp_of(phase_i, g);

    // R6
    one_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(lamps_o[g]));
  end

  // R7
  cross_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamps_o[0].red || lamps_o[1].red));

endmodule

// File: rtl/traffic_pair_ctrl.sv
module traffic_pair_ctrl
  import traffic_pair_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               timing_i,
  output logic               sig1_red,
  output logic               sig1_amber,
  output logic               sig1_green,
  output logic               sig2_red,
  output logic               sig2_amber,
  output logic               sig2_green,
  output logic [PHASE_W-1:0] phase_o
);

  phase_t            phase_w;
  logic              advance_w;
  lamp_t [SIG_N-1:0] lamps_w;

  traffic_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .timing_i  (timing_i),
    .phase_o   (phase_w),
    .advance_o (advance_w)
  );

  traffic_lamp_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase_w),
    .lamps_o (lamps_w)
  );

  assign phase_o    = phase_w;
  assign sig1_red   = lamps_w[0].red;
  assign sig1_amber = lamps_w[0].amber;
  assign sig1_green = lamps_w[0].green;
  assign sig2_red   = lamps_w[1].red;
  assign sig2_amber = lamps_w[1].amber;
  assign sig2_green = lamps_w[1].green;

  // R9
  no_step_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_w |=> ($stable(phase_o) && $stable({sig1_red, sig1_amber, sig1_green,
                                                  sig2_red, sig2_amber, sig2_green})));

endmodule

// File: tb/tb_traffic_pair_ctrl.sv
module tb_traffic_pair_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic timing_i = 1'b0;
  logic s1r, s1a, s1g, s2r, s2a, s2g;
  logic [1:0] phase_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [1:0] exp_ph = 2'd0;

  always #10 clk = ~clk;

  traffic_pair_ctrl dut (
    .clk(clk), .rst_n(rst_n), .timing_i(timing_i),
    .sig1_red(s1r), .sig1_amber(s1a), .sig1_green(s1g),
    .sig2_red(s2r), .sig2_amber(s2a), .sig2_green(s2g),
    .phase_o(phase_o)
  );

  // expected {phase, s1 r/a/g, s2 r/a/g} from phase code arithmetic
  function automatic logic [7:0] expect_vec(logic [1:0] p);
    logic [2:0] a, b;
    a = {p[1], p == 2'd1, p == 2'd0};
    b = {~p[1], p == 2'd3, p == 2'd2};
    return {p, a, b};
  endfunction

  function automatic logic [7:0] got_vec();
    return {phase_o, s1r, s1a, s1g, s2r, s2a, s2g};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_rules();
    chk("R6", {6'd0, ($countones({s1r, s1a, s1g}) == 1), ($countones({s2r, s2a, s2g}) == 1)}, 8'd3);
    chk("R7", {7'd0, (s1r | s2r)}, 8'd1);
  endtask

  // drive t at negedge, model update on edge, check at next negedge
  task automatic step(logic t);
    string req;
    if (!exp_ph[0]) req = t ? "R3" : "R2";
    else            req = t ? "R4" : "R5";
    timing_i = t;
    @(posedge clk);
    if (t != exp_ph[0]) exp_ph = exp_ph + 2'd1;
    @(negedge clk);
    chk(req, got_vec(), expect_vec(exp_ph));
    chk_rules();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, timing high must not matter during reset
    timing_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", got_vec(), expect_vec(2'd0));
    rst_n = 1'b1;
    timing_i = 1'b0;
    @(negedge clk);
    chk("R1", got_vec(), expect_vec(2'd0));

    // R8: walk through each code once
    for (int k = 0; k < 4; k++) begin
      chk("R8", got_vec(), expect_vec(exp_ph));
      step(exp_ph[0] ? 1'b0 : 1'b1);
    end

    // sweep of low/high interval lengths, two rounds each
    for (int lo = 1; lo <= 5; lo++)
      for (int hi = 1; hi <= 5; hi++)
        for (int r = 0; r < 4; r++) begin
          for (int c = 0; c < lo; c++) step(1'b0);
          for (int c = 0; c < hi; c++) step(1'b1);
        end

    // R9: glitch on timing between edges does not move outputs
    for (int k = 0; k < 4; k++) begin
      timing_i = ~exp_ph[0];
      #4;
      chk("R9", got_vec(), expect_vec(exp_ph));
      timing_i = exp_ph[0];
      #4;
      chk("R9", got_vec(), expect_vec(exp_ph));
      step(exp_ph[0]);
      step(~exp_ph[0]);
    end

    // R1: asynchronous reset in the middle of the cycle
    while (exp_ph != 2'd3) step(~exp_ph[0]);
    rst_n = 1'b0;
    #2;
    chk("R1", got_vec(), expect_vec(2'd0));
    exp_ph = 2'd0;
    timing_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0);
    step(1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule